// File: doc/BRIEF.md
# UART Data Register Queue Front-End

This block sits between a simple register interface and the serial engine of a UART. Writing the data register queues a byte for the transmitter. Reading the data register returns the oldest received byte along with its four error flags, and removes that entry. Toward the serializer the block presents a byte with a valid/ready handshake. From the deserializer it accepts a byte and a status nibble with a single-cycle valid strobe and no back-pressure.

A level input, `fifo_en_i`, selects the queue mode. When it is high, each direction has `DEPTH` entries. When it is low, each direction uses only its bottom word as a one-entry holding register. Any change of this input empties both queues. The receive side cannot stall its source, so it handles overflow by discarding the new byte and flagging the loss on the entry stored most recently. Empty and full flags for both directions let the register side poll the queues.

Top module: `uart_dr_fifo`

## Requirements
- R1: After reset both queues are empty: `tx_empty_o` and `rx_empty_o` are 1, `tx_full_o`, `rx_full_o` and `tx_valid_o` are 0, and `rdata_o` is 0.
- R2: A cycle with `wr_en_i` high and the transmit queue not full stores `wdata_i`. Stored bytes appear on `tx_data_o` in write order while `tx_valid_o` is high. The head byte is removed in each cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R3: A write in a cycle that begins with the transmit queue full is dropped, even when the serializer takes a byte in the same cycle.
- R4: Each receive entry is 12 bits. `rdata_o[7:0]` is the byte. `rdata_o[8]` is framing error, `[9]` parity error, `[10]` break and `[11]` overrun, taken from `rx_stat_i[0]` to `[3]` in the same order.
- R5: `rdata_o` shows the oldest receive entry. A cycle with `rd_en_i` high removes it, so entries are read in arrival order.
- R6: While the receive queue is empty, `rdata_o` is 0, and a read changes neither the flags nor the order of later entries.
- R7: A received byte that arrives while the receive queue is full is discarded, and bit 11 of the entry stored most recently becomes 1.
- R8: With `fifo_en_i` high, a queue reports full only after it holds `DEPTH` entries.
- R9: With `fifo_en_i` low, each queue holds one entry and reports full once it holds that entry.
- R10: One clock edge after `fifo_en_i` changes, both queues are empty. Writes, received bytes and reads presented in that cycle are discarded.
- R11: No queue ever reports empty and full at the same time, and a non-empty queue reports not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: full queue depth, 0: one-entry holding mode |
| wr_en_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Byte to transmit |
| rd_en_i | input | 1 | Data register read strobe (pops) |
| rdata_o | output | 12 | Oldest receive entry: status[11:8], byte[7:0] |
| tx_valid_o | output | 1 | Byte available to serializer |
| tx_data_o | output | 8 | Byte to serializer |
| tx_ready_i | input | 1 | Serializer takes the byte |
| rx_valid_i | input | 1 | Deserializer delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_stat_i | input | 4 | Framing, parity, break, overrun (bits 0..3) |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |

## Verification
The bench builds the block with `DEPTH` = 4. At that size, filling and overfilling both queues, with the pointers wrapping, takes only a few cycles and can be done in both modes. This makes the dropped write, the overrun mark on the last entry and the full flag at the mode's own depth easy to reach. It also feeds in all 16 status nibbles to check the placement of each flag, and it switches modes while the queues hold data and while stimulus is active in the cycle of the change.

// File: rtl/uart_dr_pkg.sv
package uart_dr_pkg;
  localparam int BYTE_W  = 8;
  localparam int STAT_W  = 4;
  localparam int ENTRY_W = BYTE_W + STAT_W;
  // status nibble bit positions
  localparam int ST_FRAME   = 0;
  localparam int ST_PARITY  = 1;
  localparam int ST_BREAK   = 2;
  localparam int ST_OVERRUN = 3;
  localparam int OVR_BIT    = BYTE_W + ST_OVERRUN;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_dr_mode.sv
module uart_dr_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_en_i,
  output logic flush_o,
  output logic single_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= fifo_en_i;
  end

  assign flush_o  = fifo_en_i ^ en_q;
  assign single_o = ~en_q;
endmodule

// File: rtl/uart_dr_queue.sv
module uart_dr_queue #(
  parameter int W        = 8,
  parameter int DEPTH    = 16,
  parameter bit MARK_EN  = 1'b0,
  parameter int MARK_BIT = W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         single_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] C_DEPTH = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx, last_ptr;
  logic [CW-1:0] count_q, cap;
  logic          push_ok, pop_ok;

  assign cap     = single_i ? CW'(1) : C_DEPTH;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q >= cap);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  // holding mode pins both pointers to the bottom word
  assign wptr_nx  = single_i ? '0 : ((wptr_q == P_LAST) ? '0 : wptr_q + 1'b1);
  assign rptr_nx  = single_i ? '0 : ((rptr_q == P_LAST) ? '0 : rptr_q + 1'b1);
  assign last_ptr = single_i ? '0 : ((wptr_q == '0) ? P_LAST : wptr_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_nx;
      if (pop_ok)  rptr_q <= rptr_nx;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (push_ok)
        mem[wptr_q] <= din_i;
      else if (MARK_EN && push_i && full_o)
        mem[last_ptr][MARK_BIT] <= 1'b1;
    end
  end

  assign dout_o = mem[rptr_q];
endmodule

// File: rtl/uart_dr_fifo.sv
module uart_dr_fifo
  import uart_dr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               wr_en_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  input  logic               rd_en_i,
  output logic [ENTRY_W-1:0] rdata_o,
  output logic               tx_valid_o,
  output logic [BYTE_W-1:0]  tx_data_o,
  input  logic               tx_ready_i,
  input  logic               rx_valid_i,
  input  logic [BYTE_W-1:0]  rx_data_i,
  input  logic [STAT_W-1:0]  rx_stat_i,
  output logic               tx_empty_o,
  output logic               tx_full_o,
  output logic               rx_empty_o,
  output logic               rx_full_o
);
  logic      flush, single;
  rx_entry_t rx_in, rx_head;

  uart_dr_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fifo_en_i(fifo_en_i),
    .flush_o  (flush),
    .single_o (single)
  );

  uart_dr_queue #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .single_i(single),
    .push_i  (wr_en_i),
    .din_i   (wdata_i),
    .pop_i   (tx_valid_o & tx_ready_i),
    .dout_o  (tx_data_o),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  assign rx_in = '{stat: rx_stat_i, data: rx_data_i};

  uart_dr_queue #(.W(ENTRY_W), .DEPTH(DEPTH), .MARK_EN(1'b1), .MARK_BIT(OVR_BIT)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .single_i(single),
    .push_i  (rx_valid_i),
    .din_i   (rx_in),
    .pop_i   (rd_en_i),
    .dout_o  (rx_head),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o)
  );

  assign tx_valid_o = ~tx_empty_o;
  assign rdata_o    = rx_empty_o ? '0 : rx_head;
endmodule

// File: rtl/uart_dr_fifo_chk.sv
module uart_dr_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fifo_en_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [11:0] rdata_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic        rx_valid_i,
  input logic        tx_empty_o,
  input logic        tx_full_o,
  input logic        rx_empty_o,
  input logic        rx_full_o
);
  AST_RD_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> (rdata_o == 12'h000)); // R6

  AST_MODE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && fifo_en_i != $past(fifo_en_i)) |=> (tx_empty_o && rx_empty_o)); // R10

  AST_TX_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && fifo_en_i == $past(fifo_en_i) && wr_en_i && !tx_full_o) |=> !tx_empty_o); // R2

  AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && fifo_en_i == $past(fifo_en_i) && tx_full_o && !(tx_valid_o && tx_ready_i))
      |=> tx_full_o); // R3

  AST_RX_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && fifo_en_i == $past(fifo_en_i) && rx_valid_i && !rx_full_o) |=> !rx_empty_o); // R5

  AST_HOLD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !fifo_en_i && !$past(fifo_en_i))
      |-> ((rx_empty_o || rx_full_o) && (tx_empty_o || tx_full_o))); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_empty_o && tx_full_o) && !(rx_empty_o && rx_full_o)); // R11
endmodule

bind uart_dr_fifo uart_dr_fifo_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .rx_valid_i(rx_valid_i),
  .tx_empty_o(tx_empty_o),
  .tx_full_o (tx_full_o),
  .rx_empty_o(rx_empty_o),
  .rx_full_o (rx_full_o)
);

// File: tb/uart_dr_fifo_tb_top.sv
module uart_dr_fifo_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        fifo_en, wr_en, rd_en, tx_ready, rx_valid;
  logic [7:0]  wdata, rx_data, tx_data;
  logic [3:0]  rx_stat;
  logic [11:0] rdata;
  logic        tx_valid, tx_empty, tx_full, rx_empty, rx_full;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_dr_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en),
    .wr_en_i   (wr_en),
    .wdata_i   (wdata),
    .rd_en_i   (rd_en),
    .rdata_o   (rdata),
    .tx_valid_o(tx_valid),
    .tx_data_o (tx_data),
    .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid),
    .rx_data_i (rx_data),
    .rx_stat_i (rx_stat),
    .tx_empty_o(tx_empty),
    .tx_full_o (tx_full),
    .rx_empty_o(rx_empty),
    .rx_full_o (rx_full)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_byte(input logic [7:0] b);
    wr_en = 1'b1; wdata = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic [3:0] s);
    rx_valid = 1'b1; rx_data = d; rx_stat = s;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd_pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    logic [3:0] st;
    rst_ni = 1'b0; fifo_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; tx_ready = 1'b0;
    rx_valid = 1'b0; wdata = '0; rx_data = '0; rx_stat = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 tx_full", tx_full, 0);
    check("R1 rx_full", rx_full, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rdata", rdata, 0);

    // R2 R8 R11: overfill tx, then drain in order
    for (int i = 0; i < DEPTH + 2; i++) begin
      wr_byte(8'(i * 37 + 5));
      check("R8 tx_full", tx_full, (i + 1 >= DEPTH) ? 1 : 0);
      check("R11 tx_empty", tx_empty, 0);
    end
    tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 tx_valid", tx_valid, 1);
      check("R2 tx_data", tx_data, 8'(i * 37 + 5));
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R3 tx_empty after drain", tx_empty, 1);

    // R3: write on full with simultaneous drain is dropped
    for (int i = 0; i < DEPTH; i++) wr_byte(8'(i + 1));
    wr_en = 1'b1; wdata = 8'hAA; tx_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3 tx_full after drop", tx_full, 0);
    cnt = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (tx_valid) begin
        cnt++;
        check("R3 data", tx_data, 8'(cnt + 1));
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R3 count", cnt, DEPTH - 1);

    // R4 R5 R7: fill rx, overflow once, read back
    for (int i = 0; i < DEPTH; i++) begin
      rx_push(8'(i * 29 + 3), 4'((i * 3 + 1) & 7));
      check("R8 rx_full", rx_full, (i + 1 >= DEPTH) ? 1 : 0);
    end
    rx_push(8'hEE, 4'h0);
    check("R7 rx_full", rx_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      st = 4'((i * 3 + 1) & 7) | ((i == DEPTH - 1) ? 4'h8 : 4'h0);
      check("R5 R7 rdata", rdata, {st, 8'(i * 29 + 3)});
      rd_pop();
    end
    check("R6 rx_empty", rx_empty, 1);
    check("R6 rdata zero", rdata, 0);
    rd_pop();
    check("R6 empty after read", rx_empty, 1);
    check("R6 full after read", rx_full, 0);
    rx_push(8'h5A, 4'h2);
    check("R6 next entry", rdata, 12'h25A);
    rd_pop();

    // R4 status sweep
    for (int s = 0; s < 16; s++) begin
      rx_push(8'(s * 17 + 1), 4'(s));
      check("R4 field", rdata, {4'(s), 8'(s * 17 + 1)});
      rd_pop();
    end

    // R10 R9: switch to holding mode with data queued
    wr_byte(8'h31); wr_byte(8'h32);
    rx_push(8'h41, 4'h0); rx_push(8'h42, 4'h0);
    fifo_en = 1'b0;
    @(negedge clk);
    check("R10 tx flushed", tx_empty, 1);
    check("R10 rx flushed", rx_empty, 1);
    wr_byte(8'hA1);
    check("R9 tx_full", tx_full, 1);
    wr_byte(8'hA2);
    check("R9 tx_data", tx_data, 8'hA1);
    rx_push(8'h11, 4'h1);
    check("R9 rx_full", rx_full, 1);
    rx_push(8'h22, 4'h0);
    check("R9 R7 rdata", rdata, 12'h911);
    rd_pop();
    check("R9 rx_empty", rx_empty, 1);

    // R10: change with write in the same cycle; R8 depth restored
    fifo_en = 1'b1; wr_en = 1'b1; wdata = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 tx dropped+flushed", tx_empty, 1);
    for (int i = 0; i < DEPTH; i++) begin
      wr_byte(8'(i));
      check("R8 depth restored", tx_full, (i + 1 >= DEPTH) ? 1 : 0);
    end
    check("R10 head", tx_data, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule